// File: doc/BRIEF.md
# Quad-Channel Latch Bus Interface

This block sits between a shared parallel bus and four 8-bit channel latches that each feed one converter channel. A host addresses the latches through two active-low group selects, one member-select bit and a read/write line. It moves data over a single bidirectional data port. A write can target one channel, or both channels that share a member position in the two groups (A with C, or B with D). A read returns one latch's contents on the same port through a three-state driver.

Each latch is transparent while it is written: its exported word follows the bus in the same cycle. When the write ends, the latch keeps the value the bus carried at the last rising clock edge of the write. Every latch value is always visible on a parallel output word. A separate output-enable signal reports when the block drives the data port.

Top module: `quad_latch_bus`

## Requirements
- R1: With `sel_ab_n` low, `sel_cd_n` high and `rd_nwr` low (write), channel A (index 0) is written when `member_sel` is 0, and channel B (index 1) when it is 1. No other channel changes.
- R2: With `sel_cd_n` low, `sel_ab_n` high and `rd_nwr` low, channel C (index 2) is written when `member_sel` is 0, and channel D (index 3) when it is 1. No other channel changes.
- R3: With both selects low and `rd_nwr` low, channels A and C are written together when `member_sel` is 0. Channels B and D are written together when it is 1.
- R4: While a channel is written, its slice `chan_q[8*i +: 8]` equals `data_io` in the same cycle, including changes between clock edges.
- R5: After a write ends, the channel keeps the value `data_io` held at the last rising clock edge of the write. Later bus activity does not change it.
- R6: With exactly one select low and `rd_nwr` high (read), the addressed channel's held value is driven on `data_io` and `db_oe` is 1.
- R7: With both selects high, no channel changes and `db_oe` is 0, whatever `member_sel`, `rd_nwr` and the bus carry.
- R8: With both selects low and `rd_nwr` high, no channel changes and `db_oe` is 0.
- R9: `db_oe` is 1 only during a valid single-channel read. Otherwise `data_io` is left in high impedance.
- R10: A rising clock edge with `rst_n` low clears all four channels to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; latches capture on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_ab_n | input | 1 | Active-low select of the A/B group |
| sel_cd_n | input | 1 | Active-low select of the C/D group |
| member_sel | input | 1 | 0 picks A or C, 1 picks B or D |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| data_io | inout | 8 | Bidirectional data bus |
| chan_q | output | 32 | Channel words, channel i at bits 8*i+7..8*i |
| db_oe | output | 1 | High while the block drives `data_io` |

## Verification
The assertions check on every cycle the rules that hold independent of data values:
- a held latch never changes,
- the bus driver is enabled only for a single-group read,
- idle selects and a dual-group read produce no write and no drive,
- single writes hit one channel and pair writes hit two.

Only the bench scenarios can show the following:
- same-cycle transparency when the bus changes between edges;
- which bus value a latch keeps when a write ends;
- the exact words returned by readback;
- the reset clearing of previously written data.

// File: rtl/qlb_pkg.sv
// Shared constants and types for the quad-channel latch bus interface.
// Assumes exactly two groups of two channels (A/B and C/D).
package qlb_pkg;

    localparam int unsigned QLB_GRP = 2;
    localparam int unsigned QLB_PER = 2;
    localparam int unsigned QLB_CH  = QLB_GRP * QLB_PER;

    typedef enum logic {
        BUS_WRITE = 1'b0,
        BUS_READ  = 1'b1
    } bus_dir_e;

endpackage

// File: rtl/qlb_decode.sv
// Address decoder: turns the two group selects, the member bit and the
// direction line into per-channel write enables and read enables.
// Assumes the package channel layout: channel i belongs to group i/2 and
// sits at member position i%2. Purely combinational.
module qlb_decode
    import qlb_pkg::*;
(
    input  logic              sel_ab_n,
    input  logic              sel_cd_n,
    input  logic              member_sel,
    input  logic              rd_nwr,
    output logic [QLB_CH-1:0] wr_en,
    output logic [QLB_CH-1:0] rd_en
);

    logic [QLB_GRP-1:0] grp_act;
    logic               one_grp;
    bus_dir_e           dir;

    // Active groups, and whether exactly one of them is addressed
    always_comb begin
        grp_act = {~sel_cd_n, ~sel_ab_n};
        one_grp = sel_ab_n ^ sel_cd_n;
        dir     = bus_dir_e'(rd_nwr);
    end

    for (genvar i = 0; i < QLB_CH; i++) begin : g_ch
        localparam int unsigned GRP  = i / QLB_PER;
        localparam logic        MEMB = 1'(i % QLB_PER);
        logic hit;
        // Channel addressed when its group is active and member bit matches
        assign hit      = grp_act[GRP] && (member_sel == MEMB);
        assign wr_en[i] = hit && (dir == BUS_WRITE);
        assign rd_en[i] = hit && (dir == BUS_READ) && one_grp;
    end

endmodule

// File: rtl/qlb_latch.sv
// One channel latch. The output follows the bus combinationally while
// written; the held register captures the bus on each rising edge of a
// write, so the value at the last edge of the write is kept afterwards.
// Assumes the bus is stable around the capturing edge.
module qlb_latch #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] hold_q;

    // Capture the bus while written; synchronous clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (wr_en)
            hold_q <= bus_in;
    end

    // Transparent path during a write, held value otherwise
    always_comb begin
        q = (wr_en && rst_n) ? bus_in : hold_q;
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hold_q));

endmodule

// File: rtl/qlb_readback.sv
// Readback path: merges the held channel words under a one-hot read
// enable and raises the bus output enable. Assumes at most one read
// enable is high (guaranteed by the decoder).
module qlb_readback
    import qlb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [QLB_CH-1:0]        rd_en,
    input  logic [QLB_CH*DATA_W-1:0] chan_words,
    output logic [DATA_W-1:0]        rb_data,
    output logic                     rb_oe
);

    // OR-merge of the enabled channel word
    always_comb begin
        rb_data = '0;
        for (int i = 0; i < QLB_CH; i++) begin
            if (rd_en[i])
                rb_data = rb_data | chan_words[i*DATA_W +: DATA_W];
        end
    end

    // Drive enable whenever any channel is read
    assign rb_oe = |rd_en;

    // R6
    rb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_oe |-> ($countones(rd_en) == 1));

endmodule

// File: rtl/quad_latch_bus.sv
// Top of the quad-channel latch bus interface: decoder, four channel
// latches and the three-state readback driver on the shared data port.
// Assumes inputs change away from the rising clock edge.
module quad_latch_bus
    import qlb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_ab_n,
    input  logic                     sel_cd_n,
    input  logic                     member_sel,
    input  logic                     rd_nwr,
    inout  wire  [DATA_W-1:0]        data_io,
    output logic [QLB_CH*DATA_W-1:0] chan_q,
    output logic                     db_oe
);

    logic [QLB_CH-1:0] wr_en;
    logic [QLB_CH-1:0] rd_en;
    logic [DATA_W-1:0] rb_data;

    qlb_decode u_dec (
        .sel_ab_n   (sel_ab_n),
        .sel_cd_n   (sel_cd_n),
        .member_sel (member_sel),
        .rd_nwr     (rd_nwr),
        .wr_en      (wr_en),
        .rd_en      (rd_en)
    );

    for (genvar i = 0; i < QLB_CH; i++) begin : g_lat
        qlb_latch #(.DATA_W(DATA_W)) u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en[i]),
            .bus_in (data_io),
            .q      (chan_q[i*DATA_W +: DATA_W])
        );
    end

    qlb_readback #(.DATA_W(DATA_W)) u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .chan_words (chan_q),
        .rb_data    (rb_data),
        .rb_oe      (db_oe)
    );

    // Three-state bus driver, released unless a valid read is active
    assign data_io = db_oe ? rb_data : 'z;

    // R1 R2
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_ab_n != sel_cd_n) && !rd_nwr) |-> ($countones(wr_en) == 1));

    // R3
    pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ab_n && !sel_cd_n && !rd_nwr) |->
            (($countones(wr_en) == 2) && (wr_en[0] != wr_en[1])));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ab_n && sel_cd_n) |-> ((wr_en == '0) && !db_oe));

    // R8
    dual_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ab_n && !sel_cd_n && rd_nwr) |-> ((wr_en == '0) && !db_oe));

    // R9
    oe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe |-> (rd_nwr && (sel_ab_n != sel_cd_n)));

endmodule

// File: tb/sim_quad_latch_bus.sv
`timescale 1ns/1ps
module sim_quad_latch_bus;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_ab_n = 1'b1;
    logic        sel_cd_n = 1'b1;
    logic        member_sel = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [7:0]  tb_data = 8'h00;
    logic        tb_drv = 1'b0;
    wire  [7:0]  data_io;
    logic [31:0] chan_q;
    logic        db_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] model [4];

    assign data_io = tb_drv ? tb_data : 'z;

    always #2.5 clk = ~clk;

    quad_latch_bus u0 (
        .clk(clk), .rst_n(rst_n), .sel_ab_n(sel_ab_n), .sel_cd_n(sel_cd_n),
        .member_sel(member_sel), .rd_nwr(rd_nwr), .data_io(data_io),
        .chan_q(chan_q), .db_oe(db_oe)
    );

    typedef struct packed {
        logic       ab_n;
        logic       cd_n;
        logic       memb;
        logic       rd;
        logic [7:0] data;
        logic [3:0] wmask;
        logic       eoe;
        logic [7:0] erb;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 4'b0001, 1'b0, 8'h00},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h22, 4'b0010, 1'b0, 8'h00},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h33, 4'b0100, 1'b0, 8'h00},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'h44, 4'b1000, 1'b0, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 4'b0000, 1'b1, 8'h11},
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 4'b0000, 1'b1, 8'h22},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 4'b0000, 1'b1, 8'h33},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 4'b0000, 1'b1, 8'h44},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 4'b0101, 1'b0, 8'h00},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h66, 4'b1010, 1'b0, 8'h00},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 4'b0000, 1'b0, 8'h00},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h88, 4'b0000, 1'b0, 8'h00},
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h99, 4'b0000, 1'b0, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 4'b0000, 1'b1, 8'h55},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 4'b0000, 1'b1, 8'h66}
    };

    // Compare one value and report a mismatch
    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Requirement covered by a table row, derived from its stimulus
    function automatic string row_tag(input vec_t v);
        if (v.rd && (v.ab_n != v.cd_n)) return "R6";
        if (v.ab_n && v.cd_n)           return "R7";
        if (!v.ab_n && !v.cd_n && v.rd) return "R8";
        if (!v.ab_n && !v.cd_n)         return "R3";
        if (!v.ab_n)                    return "R1";
        return "R2";
    endfunction

    function automatic logic [31:0] model_word();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic set_bus(input logic ab_n, input logic cd_n,
                           input logic memb, input logic rd, input logic [7:0] d);
        sel_ab_n   = ab_n;
        sel_cd_n   = cd_n;
        member_sel = memb;
        rd_nwr     = rd;
        tb_data    = d;
        tb_drv     = !(rd && (ab_n != cd_n));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 8'h00;

        // R10: reset state
        set_bus(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R10", "chan_q after reset", chan_q, 32'h0);
        chk("R9", "db_oe after reset", {31'b0, db_oe}, 32'h0);
        rst_n = 1'b1;

        // Vector table
        for (int r = 0; r < NV; r++) begin
            logic [31:0] exp_w;
            vec_t v;
            v = VECS[r];
            @(negedge clk);
            set_bus(v.ab_n, v.cd_n, v.memb, v.rd, v.data);
            #1;
            for (int i = 0; i < 4; i++)
                exp_w[i*8 +: 8] = v.wmask[i] ? v.data : model[i];
            chk(row_tag(v), $sformatf("row %0d chan_q", r), chan_q, exp_w);
            chk(v.eoe ? "R6" : "R9", $sformatf("row %0d db_oe", r),
                {31'b0, db_oe}, {31'b0, v.eoe});
            if (v.eoe)
                chk("R6", $sformatf("row %0d readback", r),
                    {24'b0, data_io}, {24'b0, v.erb});
            for (int i = 0; i < 4; i++)
                if (v.wmask[i]) model[i] = v.data;
        end

        // R4: transparency within one cycle, including mid-cycle change
        @(negedge clk);
        set_bus(1'b0, 1'b1, 1'b0, 1'b0, 8'h12);
        #1;
        chk("R4", "A follows bus", {24'b0, chan_q[7:0]}, 32'h12);
        #0.5 tb_data = 8'h34;
        #0.5;
        chk("R4", "A follows mid-cycle change", {24'b0, chan_q[7:0]}, 32'h34);
        @(negedge clk);
        tb_data = 8'h5a;
        #1;
        chk("R4", "A follows second cycle", {24'b0, chan_q[7:0]}, 32'h5a);

        // R5: value at the last edge of the write is kept
        @(negedge clk);
        set_bus(1'b1, 1'b1, 1'b0, 1'b0, 8'hc3);
        #1;
        chk("R5", "A holds after write", {24'b0, chan_q[7:0]}, 32'h5a);
        @(negedge clk);
        tb_data = 8'h0f;
        #1;
        model[0] = 8'h5a;
        chk("R5", "all channels held", chan_q, model_word());

        // R6: read back the newly held value
        @(negedge clk);
        set_bus(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        #1;
        chk("R6", "A readback", {24'b0, data_io}, 32'h5a);
        chk("R6", "db_oe on read", {31'b0, db_oe}, 32'h1);

        // R7: idle selects across two edges with write direction
        @(negedge clk);
        set_bus(1'b1, 1'b1, 1'b1, 1'b0, 8'hff);
        repeat (2) @(negedge clk);
        #1;
        chk("R7", "idle keeps channels", chan_q, model_word());

        // R10: reset clears written data
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R10", "chan_q cleared", chan_q, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule